// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block divides its input clock by a programmable integer N using a two-modulus prescaler steered by a swallow counter and a main counter. During each output period the prescaler first counts A chunks of P+1 input cycles and then B−A chunks of P cycles. The total is B chunks, so N = B·P + A. The prescaler is modelled as synchronous logic on the input clock, so each chunk is simply a count of input cycles.

Every setting is captured at a period boundary and then checked. Three settings are illegal: a swallow count larger than the main count, a main count of zero, and an unused prescaler code. An illegal setting raises an error flag and stops the output pulses. An illegal setting cannot yield a ratio that only looks valid. As an example, with a base modulus of 16 and a main count of 3, only ratios 48 to 51 can be reached. A ratio of 64 needs a main count of 4.

Top module: `dualModDivider`

## Requirements
- R1: With a legal setting, the output pulses repeat every B·P + A input cycles.
- R2: The output pulse is one input cycle wide and marks the last cycle of a period. The first pulse after reset comes in the N-th cycle after the first clock edge with reset low.
- R3: The prescaler select codes map as follows: 0 selects P=8, 1 selects P=16 and 2 selects P=64. Code 3 is illegal and sets the error flag.
- R4: A setting whose swallow count A exceeds the main count B sets the error flag in the cycle after it is loaded.
- R5: A main count B of zero sets the error flag in the cycle after it is loaded.
- R6: While the error flag is set, no output pulse is produced and the modulus-control output stays low.
- R7: Within each period, modulus control is high (divide by P+1) for the first A·(P+1) cycles and low for the rest. It never rises again before the period ends.
- R8: Select, swallow and main values that change during a period do not alter that period. They take effect from the next period.
- R9: While reset is held, the pulse, modulus-control and error outputs are all low.
- R10: While the error flag is set, the setting is re-sampled on every clock edge. When a legal setting is sampled, the flag clears after that edge and a new period of N cycles begins there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that is divided |
| rst | input | 1 | Synchronous reset, active high |
| preSel | input | 2 | Prescaler base select (0: P=8, 1: P=16, 2: P=64, 3: illegal) |
| swallowIn | input | SWALLOW_W | Swallow count A |
| mainIn | input | MAIN_W | Main count B |
| pulseOut | output | 1 | One-cycle pulse on the last cycle of each period |
| modCtl | output | 1 | High while the prescaler divides by P+1 |
| cfgErr | output | 1 | Loaded setting is illegal |

## Verification
A setting driven at a falling edge is sampled at the next period boundary. The error flag for that setting is therefore visible one cycle after the boundary pulse, or one cycle after the drive if the block is already in error. The bench counts the falling edges from one observed pulse up to the next pulse, and that count must equal N. At those same edges it counts the cycles with modulus control high and checks that they form one run at the start of the period. In the mid-period test the inputs are changed at a known cycle offset inside the period. Both the current period and the following one are then measured.

// File: rtl/dmdPkg.sv
package dmdPkg;

  localparam int MOD_W = 7;

  typedef enum logic [1:0] {
    PRE_8   = 2'd0,
    PRE_16  = 2'd1,
    PRE_64  = 2'd2,
    PRE_BAD = 2'd3
  } preSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new setting and start a period
    logic chunkEnd;  // prescaler chunk finished, period continues
    logic tick;      // count the prescaler down
  } dpStrobe_t;

  function automatic logic [MOD_W-1:0] baseMod(input logic [1:0] sel);
    case (sel)
      PRE_8:   baseMod = MOD_W'(8);
      PRE_16:  baseMod = MOD_W'(16);
      PRE_64:  baseMod = MOD_W'(64);
      default: baseMod = '0;
    endcase
  endfunction

endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import dmdPkg::*;
#(
  parameter int SWALLOW_W = 8,
  parameter int MAIN_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           preSel,
  input  logic [SWALLOW_W-1:0] swallowIn,
  input  logic [MAIN_W-1:0]    mainIn,
  input  logic                 prescZero,
  input  logic                 mainLast,
  output dpStrobe_t            strobe,
  output logic                 running,
  output logic                 periodEnd,
  output logic                 cfgErr
);

  localparam int CMP_W = (SWALLOW_W > MAIN_W) ? SWALLOW_W : MAIN_W;

  logic loaded;
  logic errQ;
  logic illegal;

  always_comb begin
    illegal = (preSel == PRE_BAD) || (mainIn == '0) ||
              (CMP_W'(swallowIn) > CMP_W'(mainIn));
  end

  assign running   = loaded && !errQ;
  assign periodEnd = running && prescZero && mainLast;
  assign cfgErr    = errQ;

  always_comb begin
    strobe.load     = !loaded || errQ || periodEnd;
    strobe.chunkEnd = running && prescZero && !mainLast;
    strobe.tick     = running && !prescZero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded <= 1'b0;
      errQ   <= 1'b0;
    end else if (strobe.load) begin
      loaded <= 1'b1;
      errQ   <= illegal;
    end
  end

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
    errQ |-> !periodEnd); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    periodEnd |=> !periodEnd); // R2
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !errQ && !periodEnd); // R9

endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import dmdPkg::*;
#(
  parameter int SWALLOW_W = 8,
  parameter int MAIN_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  dpStrobe_t            strobe,
  input  logic                 running,
  input  logic [1:0]           preSel,
  input  logic [SWALLOW_W-1:0] swallowIn,
  input  logic [MAIN_W-1:0]    mainIn,
  output logic                 prescZero,
  output logic                 mainLast,
  output logic                 swallowNz
);

  localparam int CMP_W = (SWALLOW_W > MAIN_W) ? SWALLOW_W : MAIN_W;

  logic [MOD_W-1:0]     activeP;
  logic [MOD_W-1:0]     prescCnt;
  logic [SWALLOW_W-1:0] swCnt;
  logic [MAIN_W-1:0]    mnCnt;
  logic [MOD_W-1:0]     loadMod;
  logic [SWALLOW_W-1:0] swNext;

  assign prescZero = (prescCnt == '0);
  assign mainLast  = (mnCnt == MAIN_W'(1));
  assign swallowNz = (swCnt != '0);

  always_comb begin
    loadMod = baseMod(preSel);
    swNext  = swallowNz ? swCnt - SWALLOW_W'(1) : swCnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      activeP  <= '0;
      prescCnt <= '0;
      swCnt    <= '0;
      mnCnt    <= '0;
    end else if (strobe.load) begin
      activeP  <= loadMod;
      swCnt    <= swallowIn;
      mnCnt    <= mainIn;
      // chunk length P+1 means counting P..0
      prescCnt <= (swallowIn != '0) ? loadMod : loadMod - MOD_W'(1);
    end else if (strobe.chunkEnd) begin
      mnCnt    <= mnCnt - MAIN_W'(1);
      swCnt    <= swNext;
      prescCnt <= (swNext != '0) ? activeP : activeP - MOD_W'(1);
    end else if (strobe.tick) begin
      prescCnt <= prescCnt - MOD_W'(1);
    end
  end

  AST_SWALLOW_BOUND: assert property (@(posedge clk) disable iff (rst)
    running |-> CMP_W'(swCnt) <= CMP_W'(mnCnt)); // R4
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    running && !strobe.load |=> $stable(activeP)); // R8
  AST_MOD_SINGLE_DROP: assert property (@(posedge clk) disable iff (rst)
    running && !swallowNz && !strobe.load |=> !swallowNz); // R7

endmodule

// File: rtl/dualModDivider.sv
module dualModDivider
  import dmdPkg::*;
#(
  parameter int SWALLOW_W = 8,
  parameter int MAIN_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           preSel,
  input  logic [SWALLOW_W-1:0] swallowIn,
  input  logic [MAIN_W-1:0]    mainIn,
  output logic                 pulseOut,
  output logic                 modCtl,
  output logic                 cfgErr
);

  dpStrobe_t strobe;
  logic      running;
  logic      prescZero;
  logic      mainLast;
  logic      swallowNz;
  logic      periodEnd;

  divCtrl #(.SWALLOW_W(SWALLOW_W), .MAIN_W(MAIN_W)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .preSel    (preSel),
    .swallowIn (swallowIn),
    .mainIn    (mainIn),
    .prescZero (prescZero),
    .mainLast  (mainLast),
    .strobe    (strobe),
    .running   (running),
    .periodEnd (periodEnd),
    .cfgErr    (cfgErr)
  );

  divDatapath #(.SWALLOW_W(SWALLOW_W), .MAIN_W(MAIN_W)) uPath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .running   (running),
    .preSel    (preSel),
    .swallowIn (swallowIn),
    .mainIn    (mainIn),
    .prescZero (prescZero),
    .mainLast  (mainLast),
    .swallowNz (swallowNz)
  );

  assign pulseOut = periodEnd;
  assign modCtl   = running && swallowNz;

  AST_ERR_MOD_LOW: assert property (@(posedge clk) disable iff (rst)
    cfgErr |-> !modCtl); // R6

endmodule

// File: tb/tb_dualModDivider.sv
module tb_dualModDivider;

  localparam int SW    = 8;
  localparam int MW    = 8;
  localparam int LIMIT = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    preSel = 2'd0;
  logic [SW-1:0] swallowIn = '0;
  logic [MW-1:0] mainIn = 8'd1;
  logic          pulseOut;
  logic          modCtl;
  logic          cfgErr;

  int tests = 0;
  int fails = 0;
  int modHigh;
  bit modGap;
  int cycles = 0;

  always #4 clk = ~clk;

  dualModDivider #(.SWALLOW_W(SW), .MAIN_W(MW)) dut (
    .clk(clk), .rst(rst), .preSel(preSel), .swallowIn(swallowIn),
    .mainIn(mainIn), .pulseOut(pulseOut), .modCtl(modCtl), .cfgErr(cfgErr)
  );

  function automatic int pOf(input int sel);
    return (sel == 0) ? 8 : (sel == 1) ? 16 : 64;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setCfg(input int sel, input int a, input int b);
    preSel    = 2'(sel);
    swallowIn = SW'(a);
    mainIn    = MW'(b);
  endtask

  // counts falling edges up to and including the next pulse
  task automatic measure(output int c);
    bit seenLow;
    c = 0; modHigh = 0; modGap = 0; seenLow = 0;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      c++;
      if (modCtl) begin
        modHigh++;
        if (seenLow) modGap = 1;
      end else seenLow = 1;
      if (pulseOut) break;
    end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk(!pulseOut && !modCtl && !cfgErr, "R9 reset outputs",
        {29'd0, pulseOut, modCtl, cfgErr}, 0);
  endtask

  task automatic testFirstPulse();
    int c;
    setCfg(0, 1, 2);
    rst = 1'b0;
    measure(c);
    chk(c == 17, "R2 first pulse cycle", c, 17);
    @(negedge clk);
    chk(!pulseOut, "R2 pulse width", pulseOut, 0);
    measure(c);
    chk(c == 16, "R1 ratio P8 A1 B2", c + 1, 17);
  endtask

  task automatic testB3();
    int c;
    for (int a = 0; a <= 3; a++) begin
      setCfg(1, a, 3);
      measure(c);
      measure(c);
      chk(c == 48 + a, "R1 P16 B3 ratio", c, 48 + a);
    end
    setCfg(1, 0, 4);
    measure(c);
    measure(c);
    chk(c == 64, "R1 P16 B4 A0 ratio", c, 64);
  endtask

  task automatic testSweep();
    int c;
    for (int s = 0; s < 3; s++)
      for (int b = 1; b <= 5; b++)
        for (int a = 0; a <= b; a++) begin
          setCfg(s, a, b);
          measure(c);
          measure(c);
          chk(c == b * pOf(s) + a, "R1 sweep ratio", c, b * pOf(s) + a);
          chk(modHigh == a * (pOf(s) + 1) && !modGap, "R7 modulus control run",
              modHigh, a * (pOf(s) + 1));
        end
  endtask

  task automatic testMidChange();
    int c;
    setCfg(1, 1, 2);
    measure(c);
    measure(c);
    c = 0;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      c++;
      if (c == 3) setCfg(0, 0, 3);
      if (pulseOut) break;
    end
    chk(c == 33, "R8 current period kept", c, 33);
    measure(c);
    chk(c == 24, "R8 new setting next period", c, 24);
  endtask

  task automatic testErrors();
    int c;
    int bad;
    setCfg(0, 2, 1);
    measure(c);
    @(negedge clk);
    chk(cfgErr, "R4 A>B flagged", cfgErr, 1);
    for (int b = 1; b <= 3; b++)
      for (int a = b + 1; a <= b + 2; a++) begin
        setCfg(1, a, b);
        @(negedge clk);
        chk(cfgErr, "R4 A>B flagged", cfgErr, 1);
      end
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pulseOut || modCtl) bad++;
    end
    chk(bad == 0, "R6 silent in error", bad, 0);
    setCfg(2, 0, 0);
    @(negedge clk);
    chk(cfgErr, "R5 B zero flagged", cfgErr, 1);
    setCfg(3, 1, 2);
    @(negedge clk);
    chk(cfgErr, "R3 select code 3 flagged", cfgErr, 1);
  endtask

  task automatic testRecover();
    int c;
    setCfg(2, 1, 1);
    @(negedge clk);
    chk(!cfgErr, "R10 flag cleared", cfgErr, 0);
    c = 1;
    for (int i = 0; i < LIMIT && !pulseOut; i++) begin
      @(negedge clk);
      c++;
    end
    chk(c == 65, "R10 R3 period after recovery P64", c, 65);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
      end
    end
  end

  initial begin
    testReset();
    testFirstPulse();
    testB3();
    testSweep();
    testMidChange();
    testErrors();
    testRecover();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule